// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers interrupt causes from a bank of DMA channels and folds them into four interrupt lines. Every channel keeps its own pair of cause flags, descriptor-done and error, once for each of the four lines, together with a matching enable mask. A cause flag is raised by a one-cycle event pulse from the channel, but only while that channel is running. Software clears a flag by writing a one to it. Channel direction is fixed by channel-number parity: even channels move data from memory to a device (transmit) and odd channels move data from a device to memory (receive).

For each line, two summary words report which channels have a cause that is both pending and enabled. The transmit word reports channel 2i at bit i, and the receive word reports channel 2i+1 at bit i. A third word per line collects chip-wide event flags, which a single write of all ones clears. A line is high while any bit of its transmit summary, receive summary or global word is set. Channels are started and stopped through four direction registers, all sharing the channel/2 bit position.

The register port is a plain single-cycle port. It has no back-pressure and no stream handshake. A write takes effect at the clock edge that samples it. Read data is registered and returns in the cycle after the read request.

Top module: `dma_irq_aggr`

Word address map: 0 transmit start, 1 transmit stop, 2 receive start, 3 receive stop, 4+k transmit summary of line k, 8+k receive summary of line k, 12+k global word of line k, 64+8c+k cause of channel c for line k, 68+8c+k mask of channel c for line k. Everything else is unmapped.

## Requirements
- R1: After reset every run flag, cause flag, mask bit and global bit is zero, every irq line is low and rd_data reads zero.
- R2: Writing a one to bit i of address 0 starts channel 2i, and writing it to address 2 starts channel 2i+1. Writing a one to bit i of address 1 stops channel 2i, and writing it to address 3 stops channel 2i+1. Zero bits leave the run flag alone. Reading address 0 or 1 returns the even-channel run flags at bit c/2, and reading address 2 or 3 returns the odd-channel run flags.
- R3: A done pulse (ev_done) or an error pulse (ev_err) on a running channel sets that channel's done flag (bit 0) or error flag (bit 6) in all four of its per-line cause registers, from the next cycle on. Pulses on a stopped channel change nothing.
- R4: Writing to a cause register clears each flag whose bit (0 or 6) is written as one. Flags written as zero keep their value, and the copies held for the other three lines are not touched.
- R5: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: A mask register holds enable bits at positions 0 (done) and 6 (error). Bit i of the transmit summary of line k is set when channel 2i has a cause flag that is set and enabled in its line-k mask. The receive summary does the same for channel 2i+1.
- R7: irq[k] is high exactly when the line-k transmit summary, the line-k receive summary or the line-k global word has any bit set. It follows the register state with no extra cycle of delay.
- R8: A glb_evt pulse sets the matching bits in the global word of all four lines. Writing exactly 32'hFFFF_FFFF to address 12+k clears the line-k word, and any other value is ignored. A pulse that arrives in the same cycle as the clear wins.
- R9: rd_data carries the value of the addressed register as it stood before the edge that sampled rd_en, one cycle after rd_en. Unmapped addresses and unused bit positions read as zero, and rd_data is zero in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW | Read word address |
| rd_data | output | 32 | Registered read data, one cycle after rd_en |
| ev_done | input | NUM_CH | Per-channel descriptor-done pulses |
| ev_err | input | NUM_CH | Per-channel error pulses |
| glb_evt | input | GLB_W | Chip-wide event pulses |
| irq | output | 4 | Interrupt lines |

## Verification
Cause flags, masks, run flags and global bits all update on the edge that samples the stimulus. Because irq is a pure function of that state, irq reflects a pulse or a write in the cycle that directly follows that edge. Read data lands in the same following cycle and shows the state from before the edge. The bench drives every stimulus at a falling edge and lets one rising edge pass. At the next falling edge it compares irq against the updated model, and it compares rd_data against the model value taken before that model update. The timing is therefore exercised even when a read and a write or an event share a cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  // Number of interrupt lines
  localparam int NOUT     = 4;
  // Cause and mask bit positions
  localparam int DONE_BIT = 0;
  localparam int ERR_BIT  = 6;
  // Word addresses; summary and global banks are aligned to 4 so that the
  // low two address bits select the line.
  localparam int ADR_TX_RUN  = 0;
  localparam int ADR_TX_HALT = 1;
  localparam int ADR_RX_RUN  = 2;
  localparam int ADR_RX_HALT = 3;
  localparam int ADR_TX_SUM  = 4;
  localparam int ADR_RX_SUM  = 8;
  localparam int ADR_GLB     = 12;
  localparam int ADR_CH      = 64;   // per channel: 8 words, cause 0..3, mask 4..7
  localparam int SUM_W       = 32;
endpackage

// File: rtl/dma_irq_chan.sv
module dma_irq_chan #(
  parameter int NOUT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            ev_done_i,
  input  logic            ev_err_i,
  input  logic [NOUT-1:0] cause_wr_i,
  input  logic [NOUT-1:0] mask_wr_i,
  input  logic [1:0]      wbits_i,     // {error, done}
  output logic            run_o,
  output logic [NOUT-1:0] done_o,
  output logic [NOUT-1:0] err_o,
  output logic [NOUT-1:0] mdone_o,
  output logic [NOUT-1:0] merr_o,
  output logic [NOUT-1:0] pend_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)       run_o <= 1'b0;
    else if (start_i) run_o <= 1'b1;
    else if (stop_i)  run_o <= 1'b0;
  end

  // Clear first, then set: a coinciding event keeps the flag.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o  <= '0;
      err_o   <= '0;
      mdone_o <= '0;
      merr_o  <= '0;
    end else begin
      for (int o = 0; o < NOUT; o++) begin
        done_o[o] <= (done_o[o] & ~(cause_wr_i[o] & wbits_i[0])) | (ev_done_i & run_o);
        err_o[o]  <= (err_o[o]  & ~(cause_wr_i[o] & wbits_i[1])) | (ev_err_i  & run_o);
        if (mask_wr_i[o]) begin
          mdone_o[o] <= wbits_i[0];
          merr_o[o]  <= wbits_i[1];
        end
      end
    end
  end

  assign pend_o = (done_o & mdone_o) | (err_o & merr_o);
endmodule

// File: rtl/dma_irq_glob.sv
module dma_irq_glob #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] val_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) val_o <= '0;
    else        val_o <= (val_o & ~{W{clr_i}}) | set_i;
  end
endmodule

// File: rtl/dma_irq_aggr.sv
module dma_irq_aggr
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int AW     = 10,
  parameter int GLB_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [31:0]       rd_data,
  input  logic [NUM_CH-1:0] ev_done,
  input  logic [NUM_CH-1:0] ev_err,
  input  logic [GLB_W-1:0]  glb_evt,
  output logic [NOUT-1:0]   irq
);
  localparam int CHW = AW - 3;
  localparam logic [AW-1:0] A_TXS = AW'(ADR_TX_RUN);
  localparam logic [AW-1:0] A_TXH = AW'(ADR_TX_HALT);
  localparam logic [AW-1:0] A_RXS = AW'(ADR_RX_RUN);
  localparam logic [AW-1:0] A_RXH = AW'(ADR_RX_HALT);
  localparam logic [AW-1:0] A_GLB = AW'(ADR_GLB);
  localparam logic [AW-1:0] A_CH  = AW'(ADR_CH);

  logic [NOUT-1:0]  done_q [NUM_CH];
  logic [NOUT-1:0]  err_q  [NUM_CH];
  logic [NOUT-1:0]  mdone_q[NUM_CH];
  logic [NOUT-1:0]  merr_q [NUM_CH];
  logic [NOUT-1:0]  pend   [NUM_CH];
  logic [GLB_W-1:0] glob_q [NOUT];
  logic [SUM_W-1:0] tx_sum [NOUT];
  logic [SUM_W-1:0] rx_sum [NOUT];
  logic [SUM_W-1:0] tx_run, rx_run;

  // Flat views of state, for the bound checker
  logic [NUM_CH-1:0]      run_vec;
  logic [NUM_CH*NOUT-1:0] done_vec;
  logic [NOUT*GLB_W-1:0]  glob_flat;

  // Write decode for the channel window
  logic [AW-1:0]  w_off;
  logic           w_in_ch;
  logic [CHW-1:0] w_ch;
  logic [2:0]     w_sub;
  logic [1:0]     wbits;
  assign w_off   = wr_addr - A_CH;
  assign w_in_ch = wr_en && (wr_addr >= A_CH);
  assign w_ch    = w_off[AW-1:3];
  assign w_sub   = w_off[2:0];
  assign wbits   = {wr_data[ERR_BIT], wr_data[DONE_BIT]};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int POS = c / 2;
    localparam bit ODD = (c % 2) == 1;
    logic            start_c, stop_c;
    logic [NOUT-1:0] cwr, mwr;
    assign start_c = wr_en && (wr_addr == (ODD ? A_RXS : A_TXS)) && wr_data[POS];
    assign stop_c  = wr_en && (wr_addr == (ODD ? A_RXH : A_TXH)) && wr_data[POS];
    for (genvar o = 0; o < NOUT; o++) begin : g_sel
      assign cwr[o] = w_in_ch && (w_ch == CHW'(c)) && (w_sub == {1'b0, 2'(o)});
      assign mwr[o] = w_in_ch && (w_ch == CHW'(c)) && (w_sub == {1'b1, 2'(o)});
    end
    dma_irq_chan #(.NOUT(NOUT)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_c),
      .stop_i     (stop_c),
      .ev_done_i  (ev_done[c]),
      .ev_err_i   (ev_err[c]),
      .cause_wr_i (cwr),
      .mask_wr_i  (mwr),
      .wbits_i    (wbits),
      .run_o      (run_vec[c]),
      .done_o     (done_q[c]),
      .err_o      (err_q[c]),
      .mdone_o    (mdone_q[c]),
      .merr_o     (merr_q[c]),
      .pend_o     (pend[c])
    );
    assign done_vec[c*NOUT +: NOUT] = done_q[c];
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    logic clr_o;
    assign clr_o = wr_en && (wr_addr == A_GLB + AW'(o)) && (&wr_data);
    dma_irq_glob #(.W(GLB_W)) u_glob (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (glb_evt),
      .clr_i (clr_o),
      .val_o (glob_q[o])
    );
    assign glob_flat[o*GLB_W +: GLB_W] = glob_q[o];
    assign irq[o] = (|tx_sum[o]) | (|rx_sum[o]) | (|glob_q[o]);
  end

  // Parity-split summaries and run words
  always_comb begin
    tx_run = '0;
    rx_run = '0;
    for (int o = 0; o < NOUT; o++) begin
      tx_sum[o] = '0;
      rx_sum[o] = '0;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (c % 2 == 0) tx_run[c/2] = run_vec[c];
      else            rx_run[c/2] = run_vec[c];
      for (int o = 0; o < NOUT; o++) begin
        if (c % 2 == 0) tx_sum[o][c/2] = pend[c][o];
        else            rx_sum[o][c/2] = pend[c][o];
      end
    end
  end

  // Read mux
  logic [AW-1:0] r_off;
  logic [31:0]   rd_val;
  assign r_off = rd_addr - A_CH;

  always_comb begin
    rd_val = '0;
    if (rd_addr < A_CH) begin
      if (rd_addr[AW-1:2] == '0)
        rd_val = rd_addr[1] ? rx_run : tx_run;
      else if (rd_addr[AW-1:2] == (AW-2)'(1))
        rd_val = tx_sum[rd_addr[1:0]];
      else if (rd_addr[AW-1:2] == (AW-2)'(2))
        rd_val = rx_sum[rd_addr[1:0]];
      else if (rd_addr[AW-1:2] == (AW-2)'(3))
        rd_val[GLB_W-1:0] = glob_q[rd_addr[1:0]];
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (r_off[AW-1:3] == CHW'(c)) begin
          if (!r_off[2]) begin
            rd_val[DONE_BIT] = done_q[c][r_off[1:0]];
            rd_val[ERR_BIT]  = err_q[c][r_off[1:0]];
          end else begin
            rd_val[DONE_BIT] = mdone_q[c][r_off[1:0]];
            rd_val[ERR_BIT]  = merr_q[c][r_off[1:0]];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_en ? rd_val : '0;
  end
endmodule

// File: rtl/dma_irq_aggr_chk.sv
module dma_irq_aggr_chk
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int AW     = 10,
  parameter int GLB_W  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [AW-1:0]          wr_addr,
  input logic [31:0]            wr_data,
  input logic                   rd_en,
  input logic [31:0]            rd_data,
  input logic [NUM_CH-1:0]      ev_done,
  input logic [GLB_W-1:0]       glb_evt,
  input logic [NOUT-1:0]        irq,
  input logic [NUM_CH-1:0]      run_vec,
  input logic [NUM_CH*NOUT-1:0] done_vec,
  input logic [NOUT*GLB_W-1:0]  glob_flat
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (irq == '0));

  // R9
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> (rd_data == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    localparam logic [AW-1:0] HALT = AW'((c % 2 == 0) ? ADR_TX_HALT : ADR_RX_HALT);
    // R3
    done_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_done[c] && run_vec[c]) |=> (&done_vec[c*NOUT +: NOUT]));
    // R3
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_vec[c] && !wr_en) |=> $stable(done_vec[c*NOUT +: NOUT]));
    // R2
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == HALT && wr_data[c/2]) |=> !run_vec[c]);
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_o
    // R8
    glob_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(ADR_GLB + o) && wr_data != 32'hFFFF_FFFF && glb_evt == '0)
      |=> $stable(glob_flat[o*GLB_W +: GLB_W]));
  end
endmodule

bind dma_irq_aggr dma_irq_aggr_chk #(.NUM_CH(NUM_CH), .AW(AW), .GLB_W(GLB_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .ev_done   (ev_done),
  .glb_evt   (glb_evt),
  .irq       (irq),
  .run_vec   (run_vec),
  .done_vec  (done_vec),
  .glob_flat (glob_flat)
);

// File: tb/dma_irq_aggr_test.sv
`timescale 1ns/1ps
module dma_irq_aggr_test;
  localparam int NCH = 8;
  localparam int AW  = 10;
  localparam int GW  = 8;
  localparam int NO  = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n;
  logic           wr_en, rd_en;
  logic [AW-1:0]  wr_addr, rd_addr;
  logic [31:0]    wr_data, rd_data;
  logic [NCH-1:0] ev_done, ev_err;
  logic [GW-1:0]  glb_evt;
  logic [NO-1:0]  irq;

  dma_irq_aggr #(.NUM_CH(NCH), .AW(AW), .GLB_W(GW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ev_done(ev_done),
    .ev_err(ev_err), .glb_evt(glb_evt), .irq(irq)
  );

  int n_run  = 0;
  int n_fail = 0;

  // Reference model
  bit          run_m[NCH];
  bit [1:0]    cz[NCH][NO];   // {error, done}
  bit [1:0]    mk[NCH][NO];
  bit [GW-1:0] gl[NO];

  function automatic int ca(int c, int o); return 64 + 8*c + o; endfunction
  function automatic int ma(int c, int o); return 68 + 8*c + o; endfunction

  function automatic logic [31:0] m_read(input logic [AW-1:0] a);
    logic [31:0] v = '0;
    int ai = int'(a);
    if (ai < 4) begin
      for (int i = 0; i < NCH; i++) if ((i % 2) == ai / 2) v[i/2] = run_m[i];
    end else if (ai < 8) begin
      for (int i = 0; i < NCH; i += 2) v[i/2] = |(cz[i][ai-4] & mk[i][ai-4]);
    end else if (ai < 12) begin
      for (int i = 1; i < NCH; i += 2) v[i/2] = |(cz[i][ai-8] & mk[i][ai-8]);
    end else if (ai < 16) begin
      v[GW-1:0] = gl[ai-12];
    end else if (ai >= 64 && ai < 64 + 8*NCH) begin
      int c = (ai - 64) / 8;
      int s = (ai - 64) % 8;
      bit [1:0] b = (s < 4) ? cz[c][s] : mk[c][s-4];
      v[0] = b[0];
      v[6] = b[1];
    end
    return v;
  endfunction

  function automatic logic [NO-1:0] m_irq();
    logic [NO-1:0] r;
    for (int o = 0; o < NO; o++) begin
      r[o] = (gl[o] != 0);
      for (int c = 0; c < NCH; c++) r[o] = r[o] | (|(cz[c][o] & mk[c][o]));
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [AW-1:0] a);
    int ai = int'(a);
    if (ai < 4) return "R2";
    if (ai < 12) return "R6";
    if (ai < 16) return "R8";
    if (ai >= 64 && ai < 64 + 8*NCH) return (((ai - 64) % 8) < 4) ? "R3" : "R6";
    return "R9";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_addr = '0; wr_data = '0; rd_en = 0; rd_addr = '0;
    ev_done = '0; ev_err = '0; glb_evt = '0;
  endtask

  // Drive at a falling edge, pass one rising edge, check at the next falling edge.
  task automatic step(input bit we, input int wa, input logic [31:0] wd, input bit re, input int ra,
                      input logic [NCH-1:0] ed, input logic [NCH-1:0] ee, input logic [GW-1:0] ge,
                      input string tag);
    logic [31:0]   rexp;
    logic [NO-1:0] iexp;
    bit            run_old[NCH];
    wr_en = we; wr_addr = AW'(wa); wr_data = wd; rd_en = re; rd_addr = AW'(ra);
    ev_done = ed; ev_err = ee; glb_evt = ge;
    rexp = m_read(AW'(ra));
    run_old = run_m;
    if (we) begin
      if (wa < 4) begin
        for (int i = 0; i < NCH; i++)
          if ((i % 2) == wa / 2 && wd[i/2]) run_m[i] = (wa % 2 == 0);
      end else if (wa >= 64 && wa < 64 + 8*NCH) begin
        int c = (wa - 64) / 8;
        int s = (wa - 64) % 8;
        if (s < 4) cz[c][s] = cz[c][s] & ~{wd[6], wd[0]};
        else       mk[c][s-4] = {wd[6], wd[0]};
      end else if (wa >= 12 && wa < 16 && wd == 32'hFFFF_FFFF) begin
        gl[wa-12] = '0;
      end
    end
    for (int c = 0; c < NCH; c++)
      for (int o = 0; o < NO; o++)
        if (run_old[c]) cz[c][o] = cz[c][o] | {ee[c], ed[c]};
    for (int o = 0; o < NO; o++) gl[o] = gl[o] | ge;
    @(posedge clk);
    @(negedge clk);
    iexp = m_irq();
    chk(irq === iexp, tag, 32'(irq), 32'(iexp));
    if (re) chk(rd_data === rexp, tag, rd_data, rexp);
    idle();
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag);
    step(1, a, d, 0, 0, '0, '0, '0, tag);
  endtask
  task automatic rd(input int a, input string tag);
    step(0, 0, '0, 1, a, '0, '0, '0, tag);
  endtask
  task automatic ev(input logic [NCH-1:0] ed, input logic [NCH-1:0] ee, input logic [GW-1:0] ge, input string tag);
    step(0, 0, '0, 0, 0, ed, ee, ge, tag);
  endtask

  initial begin
    #(64'd200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 outputs during reset
    chk(irq === '0, "R1", 32'(irq), 32'h0);
    chk(rd_data === '0, "R1", rd_data, 32'h0);
    rst_n = 1'b1;

    rd(0, "R1"); rd(2, "R1"); rd(ca(0, 0), "R1"); rd(ma(5, 3), "R1"); rd(12, "R1");

    // R3 stopped channel ignores events
    ev(8'h01, 8'h01, '0, "R3"); rd(ca(0, 0), "R3");
    // R2 start transmit channel 0 and receive channel 3
    wr(0, 32'h1, "R2"); rd(0, "R2"); rd(1, "R2");
    wr(2, 32'h2, "R2"); rd(2, "R2");
    // R3 capture on all four lines
    ev(8'h01, '0, '0, "R3"); rd(ca(0, 2), "R3"); rd(ca(0, 0), "R3");
    // R6 enable line 1 for channel 0
    wr(ma(0, 1), 32'h1, "R6"); rd(5, "R6"); rd(ma(0, 1), "R6");
    ev('0, 8'h08, '0, "R3"); wr(ma(3, 0), 32'h40, "R6"); rd(8, "R6");
    // R5 clear and set in the same cycle
    step(1, ca(0, 1), 32'h1, 0, 0, 8'h01, '0, '0, "R5"); rd(ca(0, 1), "R5");
    // R4 zero bits keep, one bits clear, other lines untouched
    wr(ca(0, 1), 32'h0, "R4"); rd(ca(0, 1), "R4");
    wr(ca(0, 1), 32'h1, "R4"); rd(ca(0, 1), "R4"); rd(ca(0, 2), "R4");
    // R2 stop receive channel 3, then R3 its events are ignored
    wr(3, 32'h2, "R2"); rd(2, "R2");
    wr(ca(3, 0), 32'h40, "R4"); ev('0, 8'h08, '0, "R3"); rd(ca(3, 0), "R3");
    // R8 global words
    ev('0, '0, 8'h05, "R8"); rd(12, "R8"); rd(15, "R8");
    wr(12, 32'h0000_FFFF, "R8"); rd(12, "R8");
    step(1, 13, 32'hFFFF_FFFF, 0, 0, '0, '0, 8'h10, "R8"); rd(13, "R8");
    wr(12, 32'hFFFF_FFFF, "R8"); rd(12, "R8"); rd(14, "R8");
    // R9 unused bits and unmapped addresses
    wr(ma(2, 3), 32'hFFFF_FFFF, "R9"); rd(ma(2, 3), "R9");
    rd(32, "R9"); rd(64 + 8*NCH, "R9");

    // R7 constrained random traffic
    for (int n = 0; n < 600; n++) begin
      int kind = int'($urandom % 5);
      int wa;
      logic [31:0] wd = $urandom;
      bit we = ($urandom % 2) == 1;
      bit re = ($urandom % 2) == 1;
      int ra;
      int rk = int'($urandom % 4);
      case (kind)
        0: wa = int'($urandom % 4);
        1: wa = ca(int'($urandom % NCH), int'($urandom % NO));
        2: wa = ma(int'($urandom % NCH), int'($urandom % NO));
        3: begin wa = 12 + int'($urandom % NO); if ($urandom % 2 == 1) wd = 32'hFFFF_FFFF; end
        default: wa = 16 + int'($urandom % 48);
      endcase
      case (rk)
        0: ra = int'($urandom % 16);
        1: ra = ca(int'($urandom % NCH), int'($urandom % NO));
        2: ra = ma(int'($urandom % NCH), int'($urandom % NO));
        default: ra = int'($urandom % 160);
      endcase
      step(we, wa, wd, re, ra, NCH'($urandom & $urandom & $urandom), NCH'($urandom & $urandom & $urandom),
           (($urandom % 6) == 0) ? GW'($urandom) : '0, re ? tag_of(AW'(ra)) : "R7");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule